// File: doc/BRIEF.md
# Initialization Command Sequencer

The sequencer walks a list of 64-bit initialization commands and turns each one into transactions on a simple register bus. A start pulse supplies a first index and an end index. Commands are fetched one at a time through a command ROM read port and executed strictly in order, from the first index up to but not including the end index. Each command is one of five kinds: a register read, a single register write, a word-by-word copy from a data ROM, a burst copy from the data ROM split into bounded chunks, or a zero fill of a memory region, also split into chunks.

The first 32-bit word of a command (bits [31:0]) carries the opcode in bits [7:0] and a 24-bit target offset in bits [31:8]. The meaning of the second word (bits [63:32]) depends on the opcode. Multi-word operations write word i to the target offset plus 4*i. Both ROMs sit next to the block and are read combinationally: the block drives an index and the word comes back in the same cycle. Commands the block cannot execute, and fills or bursts larger than the staging buffer, raise a sticky error flag and are skipped. A one-cycle done pulse marks the end of the list.

Top module: `initseq_top`

## Requirements
- R1: Opcode 2 (single write) issues exactly one write of the second word (bits [63:32]) to the offset in bits [31:8], with the read strobe low.
- R2: Opcode 1 (single read) issues exactly one read strobe at the offset in bits [31:8], with the write enable low.
- R3: Opcode 4 (string copy) takes a data ROM offset from bits [47:32] and a length in words from bits [63:48]. It writes data ROM word offset+i to address target+4*i for i = 0..length-1, with the chunk-end flag low. A length of 0 issues nothing and raises no error.
- R4: Opcode 8 (burst copy) uses the same fields and addressing as R3. It marks the end of each chunk by raising bus_eoc on a write that is either the MAX_BURST-th write of its chunk or the last write of the command. Address and source advance across chunks without gaps.
- R5: Opcode 6 (zero fill) writes the value 0 to target+4*i for i below the full 32-bit length in bits [63:32]. It is chunked and flagged as in R4.
- R6: A burst copy or zero fill whose length exceeds BUF_WORDS issues no transaction and sets the error flag. A length equal to BUF_WORDS is executed.
- R7: Opcodes 0, 3, 5, 7 and any value above 8 issue no transaction and set the error flag. Execution continues with the next command.
- R8: Commands execute in index order from first_idx up to last_idx-1. If first_idx >= last_idx, nothing is issued.
- R9: A bus transaction holds its address, data, write enable and read strobe stable until bus_ready is sampled high. The write enable and read strobe are never both high.
- R10: done pulses high for exactly one cycle once the list has finished. err stays set until the next accepted start, which clears it.
- R11: A start pulse while a list is running is ignored.
- R12: After reset, the write enable, read strobe, chunk-end flag, done and err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; accepted only when idle |
| first_idx | input | IDX_W | Index of the first command |
| last_idx | input | IDX_W | Index one past the last command |
| cmd_idx | output | IDX_W | Command ROM read index |
| cmd_word | input | 64 | Command ROM word at cmd_idx |
| dat_idx | output | 16 | Data ROM read index |
| dat_word | input | 32 | Data ROM word at dat_idx |
| bus_addr | output | 32 | Register bus address |
| bus_wdata | output | 32 | Register bus write data |
| bus_we | output | 1 | Register bus write enable |
| bus_re | output | 1 | Register bus read strobe |
| bus_ready | input | 1 | Register bus accepts the current transaction |
| bus_eoc | output | 1 | Current write closes a chunk |
| done | output | 1 | One-cycle pulse at end of list |
| err | output | 1 | Sticky error flag |

## Verification
The bench targets several boundary cases:
- Burst lengths one past a chunk boundary (17) and exactly on one (16). A chunk counter that is off by one shows up as a misplaced or missing chunk-end flag.
- Fill and burst lengths of exactly BUF_WORDS and one above it, plus a fill length with bits set above bit 15. A wrong bound or a truncated length check either drops a legal command or emits writes for an illegal one.
- Empty and inverted index ranges, zero-length copies, unsupported opcodes placed between legal commands, and a start pulse in the middle of a run. A sequencer that stalls, restarts or skips shows up as a wrong transaction stream or a missing done pulse.
- Random stalls on the ready line. A design that advances without a handshake loses or duplicates writes.

// File: rtl/initseq_pkg.sv
package initseq_pkg;

  typedef enum logic [2:0] {
    K_READ,
    K_WRITE,
    K_COPY,
    K_BURST,
    K_FILL,
    K_BAD
  } kind_e;

  localparam logic [7:0] OPC_READ  = 8'd1;
  localparam logic [7:0] OPC_WRITE = 8'd2;
  localparam logic [7:0] OPC_COPY  = 8'd4;
  localparam logic [7:0] OPC_FILL  = 8'd6;
  localparam logic [7:0] OPC_BURST = 8'd8;

  typedef struct packed {
    kind_e       kind;
    logic [31:0] base;
    logic [31:0] len;
    logic [15:0] src;
    logic [31:0] value;
    logic        reject;
  } cmd_t;

endpackage

// File: rtl/initseq_decode.sv
module initseq_decode
  import initseq_pkg::*;
#(
  parameter int BUF_WORDS = 256
) (
  input  logic [63:0] cmd_word,
  output cmd_t        cmd
);

  logic [7:0]  opc;
  logic [31:0] arg;

  assign opc = cmd_word[7:0];
  assign arg = cmd_word[63:32];

  always_comb begin
    cmd        = '0;
    cmd.base   = {8'h00, cmd_word[31:8]};
    cmd.kind   = K_BAD;
    cmd.reject = 1'b1;
    unique case (opc)
      OPC_READ: begin
        cmd.kind   = K_READ;
        cmd.len    = 32'd1;
        cmd.reject = 1'b0;
      end
      OPC_WRITE: begin
        cmd.kind   = K_WRITE;
        cmd.len    = 32'd1;
        cmd.value  = arg;
        cmd.reject = 1'b0;
      end
      OPC_COPY: begin
        cmd.kind   = K_COPY;
        cmd.len    = {16'h0000, arg[31:16]};
        cmd.src    = arg[15:0];
        cmd.reject = 1'b0;
      end
      OPC_BURST: begin
        cmd.kind   = K_BURST;
        cmd.len    = {16'h0000, arg[31:16]};
        cmd.src    = arg[15:0];
        cmd.reject = ({16'h0000, arg[31:16]} > 32'(BUF_WORDS));
      end
      OPC_FILL: begin
        cmd.kind   = K_FILL;
        cmd.len    = arg;
        cmd.reject = (arg > 32'(BUF_WORDS));
      end
      default: begin
        cmd.kind   = K_BAD;
        cmd.reject = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/initseq_chunk.sv
module initseq_chunk #(
  parameter int MAX_BURST = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic step,
  input  logic last,
  output logic eoc
);

  localparam int CW = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;

  assign eoc = en && ((cnt_q == CW'(MAX_BURST - 1)) || last);

  always_comb begin
    cnt_ce = clr || step;
    cnt_d  = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (step)
      cnt_d = eoc ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_ce)
      cnt_q <= cnt_d;
  end

endmodule

// File: rtl/initseq_engine.sv
module initseq_engine
  import initseq_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int MAX_BURST = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] first_idx,
  input  logic [IDX_W-1:0] last_idx,
  input  cmd_t             cmd,
  output logic [IDX_W-1:0] cmd_idx,
  output logic [15:0]      dat_idx,
  input  logic [31:0]      dat_word,
  output logic [31:0]      bus_addr,
  output logic [31:0]      bus_wdata,
  output logic             bus_we,
  output logic             bus_re,
  input  logic             bus_ready,
  output logic             bus_eoc,
  output logic             done,
  output logic             err
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_BEAT} state_e;

  state_e           st_q, st_d;
  logic [IDX_W-1:0] cidx_q, cidx_d;
  logic [IDX_W-1:0] eidx_q, eidx_d;
  kind_e            kind_q;
  logic [31:0]      base_q, len_q, val_q, beat_q, beat_d;
  logic [15:0]      src_q;
  logic             err_q, err_d;
  logic             done_q, done_d;
  logic             load, beat_ce, idx_ce, last_beat, in_beat, chunked;

  assign in_beat   = (st_q == S_BEAT);
  assign last_beat = (beat_q == len_q - 32'd1);
  assign chunked   = (kind_q == K_BURST) || (kind_q == K_FILL);

  always_comb begin
    st_d    = st_q;
    cidx_d  = cidx_q;
    eidx_d  = eidx_q;
    beat_d  = beat_q;
    err_d   = err_q;
    done_d  = 1'b0;
    load    = 1'b0;
    beat_ce = 1'b0;
    idx_ce  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          cidx_d = first_idx;
          eidx_d = last_idx;
          err_d  = 1'b0;
          idx_ce = 1'b1;
          st_d   = S_FETCH;
        end
      end
      S_FETCH: begin
        if (cidx_q >= eidx_q) begin
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else if (cmd.reject) begin
          err_d  = 1'b1;
          cidx_d = cidx_q + 1'b1;
          idx_ce = 1'b1;
        end else if (cmd.len == 32'd0) begin
          cidx_d = cidx_q + 1'b1;
          idx_ce = 1'b1;
        end else begin
          load    = 1'b1;
          beat_d  = '0;
          beat_ce = 1'b1;
          st_d    = S_BEAT;
        end
      end
      S_BEAT: begin
        if (bus_ready) begin
          if (last_beat) begin
            cidx_d = cidx_q + 1'b1;
            idx_ce = 1'b1;
            st_d   = S_FETCH;
          end else begin
            beat_d  = beat_q + 32'd1;
            beat_ce = 1'b1;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cidx_q <= '0;
      eidx_q <= '0;
    end else if (idx_ce) begin
      cidx_q <= cidx_d;
      eidx_q <= eidx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      beat_q <= '0;
    else if (beat_ce)
      beat_q <= beat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_READ;
      base_q <= '0;
      len_q  <= '0;
      val_q  <= '0;
      src_q  <= '0;
    end else if (load) begin
      kind_q <= cmd.kind;
      base_q <= cmd.base;
      len_q  <= cmd.len;
      val_q  <= cmd.value;
      src_q  <= cmd.src;
    end
  end

  initseq_chunk #(.MAX_BURST(MAX_BURST)) u_chunk (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (st_q == S_FETCH),
    .en   (in_beat && chunked),
    .step (in_beat && bus_ready),
    .last (last_beat),
    .eoc  (bus_eoc)
  );

  always_comb begin
    unique case (kind_q)
      K_WRITE:         bus_wdata = val_q;
      K_COPY, K_BURST: bus_wdata = dat_word;
      default:         bus_wdata = 32'd0;
    endcase
  end

  assign cmd_idx  = cidx_q;
  assign dat_idx  = src_q + beat_q[15:0];
  assign bus_addr = base_q + (beat_q << 2);
  assign bus_we   = in_beat && (kind_q != K_READ);
  assign bus_re   = in_beat && (kind_q == K_READ);
  assign done     = done_q;
  assign err      = err_q;

endmodule

// File: rtl/initseq_top.sv
module initseq_top
  import initseq_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int BUF_WORDS = 256,
  parameter int MAX_BURST = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] first_idx,
  input  logic [IDX_W-1:0] last_idx,
  output logic [IDX_W-1:0] cmd_idx,
  input  logic [63:0]      cmd_word,
  output logic [15:0]      dat_idx,
  input  logic [31:0]      dat_word,
  output logic [31:0]      bus_addr,
  output logic [31:0]      bus_wdata,
  output logic             bus_we,
  output logic             bus_re,
  input  logic             bus_ready,
  output logic             bus_eoc,
  output logic             done,
  output logic             err
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  cmd_t       cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_core_n = rst_sync_q[1];

  initseq_decode #(.BUF_WORDS(BUF_WORDS)) u_decode (
    .cmd_word(cmd_word),
    .cmd     (cmd)
  );

  initseq_engine #(.IDX_W(IDX_W), .MAX_BURST(MAX_BURST)) u_engine (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start    (start),
    .first_idx(first_idx),
    .last_idx (last_idx),
    .cmd      (cmd),
    .cmd_idx  (cmd_idx),
    .dat_idx  (dat_idx),
    .dat_word (dat_word),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_ready(bus_ready),
    .bus_eoc  (bus_eoc),
    .done     (done),
    .err      (err)
  );

endmodule

// File: rtl/initseq_chk.sv
module initseq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_we,
  input logic        bus_re,
  input logic        bus_ready,
  input logic        bus_eoc,
  input logic        done,
  input logic        err
);

  // R9
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_we || bus_re) && !bus_ready) |=>
      ($stable(bus_we) && $stable(bus_re) && $stable(bus_addr) && $stable(bus_wdata)));

  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  // R4
  eoc_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_eoc |-> bus_we);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

  // R8
  quiet_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(bus_we || bus_re));

endmodule

bind initseq_top initseq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_we   (bus_we),
  .bus_re   (bus_re),
  .bus_ready(bus_ready),
  .bus_eoc  (bus_eoc),
  .done     (done),
  .err      (err)
);

// File: tb/initseq_top_test.sv
`timescale 1ns/1ps
module initseq_top_test;

  localparam int IDX_W = 6;
  localparam int BUFW  = 256;
  localparam int MB    = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [IDX_W-1:0] first_idx, last_idx;
  logic [IDX_W-1:0] cmd_idx;
  logic [63:0]      cmd_word;
  logic [15:0]      dat_idx;
  logic [31:0]      dat_word;
  logic [31:0]      bus_addr, bus_wdata;
  logic             bus_we, bus_re, bus_ready, bus_eoc, done, err;

  logic [63:0] cmd_mem [0:63];
  logic [31:0] dat_mem [0:1023];

  assign cmd_word = cmd_mem[cmd_idx];
  assign dat_word = dat_mem[dat_idx[9:0]];

  always #2.5 clk = ~clk;

  initseq_top #(.IDX_W(IDX_W), .BUF_WORDS(BUFW), .MAX_BURST(MB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_idx(first_idx),
    .last_idx(last_idx), .cmd_idx(cmd_idx), .cmd_word(cmd_word),
    .dat_idx(dat_idx), .dat_word(dat_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_ready(bus_ready), .bus_eoc(bus_eoc), .done(done), .err(err)
  );

  int    tests = 0;
  int    fails = 0;
  int    cyc   = 0;
  int    done_cnt;
  int    pos;
  bit    exp_err;
  bit    finished = 0;
  bit    ready_always = 0;

  logic [31:0] ex_addr [$];
  logic [31:0] ex_data [$];
  logic        ex_we   [$];
  logic        ex_eoc  [$];
  string       ex_tag  [$];

  bit          hold_pend = 0;
  logic [31:0] h_addr, h_data;
  logic        h_we, h_re;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] op, input logic [23:0] off,
                                     input logic [31:0] arg);
    return {arg, off, op};
  endfunction

  task automatic add(input logic [31:0] a, input logic [31:0] d, input logic we,
                     input logic eoc, input string tag);
    ex_addr.push_back(a); ex_data.push_back(d); ex_we.push_back(we);
    ex_eoc.push_back(eoc); ex_tag.push_back(tag);
  endtask

  task automatic build(input int f, input int l);
    ex_addr.delete(); ex_data.delete(); ex_we.delete(); ex_eoc.delete(); ex_tag.delete();
    exp_err = 0;
    for (int i = f; i < l; i++) begin
      logic [63:0] w;
      logic [31:0] base, arg;
      int n;
      w    = cmd_mem[i];
      base = {8'h00, w[31:8]};
      arg  = w[63:32];
      case (w[7:0])
        8'd1: add(base, 32'd0, 1'b0, 1'b0, "R2");
        8'd2: add(base, arg, 1'b1, 1'b0, "R1");
        8'd4: begin
          n = int'(arg[31:16]);
          for (int j = 0; j < n; j++)
            add(base + 32'(4*j), dat_mem[(int'(arg[15:0]) + j) % 1024], 1'b1, 1'b0, "R3");
        end
        8'd8: begin
          n = int'(arg[31:16]);
          if (n > BUFW) exp_err = 1;
          else for (int j = 0; j < n; j++)
            add(base + 32'(4*j), dat_mem[(int'(arg[15:0]) + j) % 1024], 1'b1,
                (j % MB == MB-1) || (j == n-1), "R4");
        end
        8'd6: begin
          if (arg > 32'(BUFW)) exp_err = 1;
          else for (int j = 0; j < int'(arg); j++)
            add(base + 32'(4*j), 32'd0, 1'b1, (j % MB == MB-1) || (j == int'(arg)-1), "R5");
        end
        default: exp_err = 1;
      endcase
    end
  endtask

  // bus model and monitor: ready picked and handshake judged at the negedge
  always @(negedge clk) begin
    bit r;
    cyc++;
    r = ready_always ? 1'b1 : (($urandom % 4) != 0);
    bus_ready = r;
    if (rst_n) begin
      if (hold_pend) begin
        check(bus_we == h_we && bus_re == h_re && bus_addr == h_addr &&
              (!h_we || bus_wdata == h_data), "R9", "stall hold addr", bus_addr, h_addr);
      end
      hold_pend = (bus_we || bus_re) && !r;
      h_addr = bus_addr; h_data = bus_wdata; h_we = bus_we; h_re = bus_re;
      if ((bus_we || bus_re) && r) begin
        if (pos >= ex_addr.size()) begin
          check(1'b0, "R8", "unexpected transaction", bus_addr, 32'hFFFFFFFF);
        end else begin
          string t;
          t = ex_tag[pos];
          check(bus_addr == ex_addr[pos], t, "addr", bus_addr, ex_addr[pos]);
          check(bus_we == ex_we[pos] && bus_re == !ex_we[pos], t, "strobe",
                {30'd0, bus_we, bus_re}, {30'd0, ex_we[pos], !ex_we[pos]});
          if (ex_we[pos])
            check(bus_wdata == ex_data[pos], t, "wdata", bus_wdata, ex_data[pos]);
          check(bus_eoc == ex_eoc[pos], (t == "R3") ? "R3" : "R4", "chunk end",
                {31'd0, bus_eoc}, {31'd0, ex_eoc[pos]});
        end
        pos++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 190000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      finish_run();
    end
  end

  task automatic run(input int f, input int l, input bit poke, input bit prev_err);
    int t;
    check(err == prev_err, "R10", "err held before start", {31'd0, err}, {31'd0, prev_err});
    build(f, l);
    pos = 0;
    done_cnt = 0;
    @(negedge clk);
    start = 1'b1; first_idx = IDX_W'(f); last_idx = IDX_W'(l);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; first_idx = '0; last_idx = 6'd63;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && t < 30000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
    check(pos == ex_addr.size(), poke ? "R11" : "R8", "transaction count", pos, ex_addr.size());
    check(err == exp_err, exp_err ? "R6" : "R7", "error flag", {31'd0, err}, {31'd0, exp_err});
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; first_idx = '0; last_idx = '0; bus_ready = 1'b0;
    for (int i = 0; i < 64; i++) cmd_mem[i] = 64'd0;
    for (int i = 0; i < 1024; i++) dat_mem[i] = $urandom;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 idle after reset
    check(!bus_we && !bus_re && !bus_eoc, "R12", "bus idle", {29'd0, bus_we, bus_re, bus_eoc}, 0);
    check(!done && !err, "R12", "flags low", {30'd0, done, err}, 0);

    // directed: every kind plus unsupported codes in between (R1 R2 R3 R4 R5 R7)
    cmd_mem[0] = mk(8'd2, 24'h000100, 32'hDEADBEEF);
    cmd_mem[1] = mk(8'd1, 24'h000200, 32'h0);
    cmd_mem[2] = mk(8'd4, 24'h000300, {16'd5, 16'd10});
    cmd_mem[3] = mk(8'd8, 24'h000400, {16'd17, 16'd100});
    cmd_mem[4] = mk(8'd6, 24'h000800, 32'd3);
    cmd_mem[5] = mk(8'd3, 24'h000900, 32'd7);
    cmd_mem[6] = mk(8'd8, 24'h000A00, {16'd0, 16'd5});
    cmd_mem[7] = mk(8'd7, 24'h000B00, 32'd1);
    cmd_mem[8] = mk(8'd2, 24'h000104, 32'h00000001);
    run(0, 9, 0, 0);

    // boundaries of the staging buffer and chunk size (R6 R4 R5)
    cmd_mem[10] = mk(8'd6, 24'h001000, 32'd256);
    cmd_mem[11] = mk(8'd8, 24'h002000, {16'd257, 16'd0});
    cmd_mem[12] = mk(8'd6, 24'h003000, 32'd257);
    cmd_mem[13] = mk(8'd6, 24'h004000, 32'h00010001);
    cmd_mem[14] = mk(8'd8, 24'h005000, {16'd16, 16'd40});
    cmd_mem[15] = mk(8'd8, 24'h006000, {16'd256, 16'd500});
    run(10, 16, 0, 1);

    // clean list with a start during the run (R11), err cleared (R10)
    cmd_mem[20] = mk(8'd2, 24'h00F000, 32'h12345678);
    cmd_mem[21] = mk(8'd4, 24'h00F100, {16'd30, 16'd900});
    cmd_mem[22] = mk(8'd8, 24'h00F200, {16'd33, 16'd1000});
    cmd_mem[23] = mk(8'd6, 24'h00F400, 32'd0);
    cmd_mem[24] = mk(8'd4, 24'h00F500, {16'd0, 16'd3});
    run(20, 25, 1, 1);

    // empty and inverted ranges (R8), with ready always high
    ready_always = 1;
    run(30, 30, 0, 0);
    run(40, 35, 0, 0);
    ready_always = 0;

    // random lists
    for (int it = 0; it < 10; it++) begin
      int f, l;
      bit pe;
      pe = err;
      for (int i = 0; i < 64; i++) begin
        int k;
        logic [7:0] op;
        logic [15:0] ln;
        k  = $urandom % 11;
        ln = 16'($urandom % 40);
        if (($urandom % 8) == 0) ln = 16'(250 + $urandom % 12);
        case (k)
          0: op = 8'd1;
          1, 2: op = 8'd2;
          3: op = 8'd4;
          4, 5: op = 8'd8;
          6, 7: op = 8'd6;
          8: op = 8'd0;
          9: op = (($urandom % 2) != 0) ? 8'd5 : 8'd9;
          default: op = 8'hFF;
        endcase
        if (op == 8'd6)
          cmd_mem[i] = mk(op, 24'($urandom), {16'd0, ln});
        else
          cmd_mem[i] = mk(op, 24'($urandom), {ln, 16'($urandom)});
      end
      f = $urandom % 40;
      l = f + 1 + ($urandom % 20);
      run(f, l, 0, pe);
    end

    finish_run();
  end

endmodule